// File: doc/BRIEF.md
# Far Transfer Privilege Checker

This block decides whether a far jump, far call or far return between code segments is allowed by the privilege rules of a segmented protection scheme. The sequencer that has already fetched the target code descriptor (and the gate descriptor, when the transfer goes through a call gate) presents the current privilege level, the requested level from the selector, the target descriptor's privilege level and conforming bit, the gate's privilege level, the transfer kind and, for returns, the requested level of the saved code selector. The block answers with pass or fault, the privilege level that will be current after the transfer, and a request to switch stacks.

For a return that moves to a less privileged level, the block also marks which data segment registers must be loaded with the null selector. A register is marked when it is in use and its descriptor level is numerically below the new current level. Fetching descriptors, reading the stack pointers of the new level and moving the stack contents stay with the caller.

The block takes one request per strobe and gives its registered result one clock cycle later. Between strobes, the last result stays on the outputs.

Top module: `far_xfer_priv_chk`

## Requirements
- R1: A direct transfer (kind 00 or 01 with `via_gate`=0) to a nonconforming target (`tgt_conf`=0) passes only if `cur_pl` equals `tgt_dpl` and `sel_rpl` is less than or equal to `cur_pl`. The new level equals `cur_pl` and no stack switch is requested.
- R2: A direct transfer to a conforming target (`tgt_conf`=1) passes only if `cur_pl` is greater than or equal to `tgt_dpl`, whatever the value of `sel_rpl`. The new level stays `cur_pl`, even when it differs from `tgt_dpl`.
- R3: A gated transfer (kind 00 or 01 with `via_gate`=1) faults whenever max(`cur_pl`, `sel_rpl`) is greater than `gate_dpl`.
- R4: A gated call (kind 01) to a nonconforming target passes when `cur_pl` is greater than or equal to `tgt_dpl`. The new level becomes `tgt_dpl`, and a stack switch is requested exactly when that level differs from `cur_pl`.
- R5: A gated call to a conforming target passes when `cur_pl` is greater than or equal to `tgt_dpl`. It keeps `cur_pl` and never requests a stack switch.
- R6: A gated jump (kind 00) requires `cur_pl` equal to `tgt_dpl` for a nonconforming target, and `cur_pl` greater than or equal to `tgt_dpl` for a conforming one. It never changes the level and never switches stacks.
- R7: A return (kind 10, `via_gate` ignored) passes only if `ret_rpl` is greater than or equal to `cur_pl`, and the target matches the return level: `tgt_dpl` equal to `ret_rpl` when nonconforming, `tgt_dpl` at most `ret_rpl` when conforming. The new level is `ret_rpl`, and a stack switch is requested exactly when `ret_rpl` differs from `cur_pl`.
- R8: After a passing return with `ret_rpl` greater than `cur_pl`, bit i of `null_mask` is 1 exactly when `seg_live[i]` is 1 and the level in `seg_dpl[i*2 +: 2]` is less than `ret_rpl`. In every other case `null_mask` is 0.
- R9: Kind 11 is reserved and always faults. For every fault, `new_pl` equals `cur_pl`, `stk_switch` is 0 and `null_mask` is 0.
- R10: The result appears one cycle after `req_valid` is high. `rsp_valid` is a one-cycle pulse in that cycle. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| kind | input | 2 | 00 jump, 01 call, 10 return, 11 reserved |
| via_gate | input | 1 | Transfer goes through a call gate |
| cur_pl | input | PL_W | Current privilege level |
| sel_rpl | input | PL_W | Requested level of the target selector |
| tgt_dpl | input | PL_W | Privilege level of the target code descriptor |
| tgt_conf | input | 1 | Target code segment is conforming |
| gate_dpl | input | PL_W | Privilege level of the gate |
| ret_rpl | input | PL_W | Requested level of the saved code selector |
| seg_dpl | input | NSEG*PL_W | Descriptor levels of the data segment registers |
| seg_live | input | NSEG | Data segment register holds a non-null selector |
| rsp_valid | output | 1 | Result strobe |
| rsp_ok | output | 1 | Transfer allowed |
| new_pl | output | PL_W | Privilege level after the transfer |
| stk_switch | output | 1 | Stack switch requested |
| null_mask | output | NSEG | Data segment registers to load with null |

## Verification
A wrong decision term shows up on `rsp_ok` in the cycle after the strobe. A wrong level selection shows up on `new_pl` and `stk_switch` in that same cycle. Gated calls that raise privilege and returns that lower it expose the level mux and the stack switch flag, because the new level there differs from `cur_pl`. A wrong comparison in the null-marking logic appears on `null_mask` only for returns that lower privilege. The bench therefore feeds such returns with segment levels below, equal to and above the new level, and with some registers not in use.

// File: rtl/far_xfer_priv_chk.sv
module far_xfer_priv_chk #(
  parameter int PL_W = 2,
  parameter int NSEG = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           kind,
  input  logic                 via_gate,
  input  logic [PL_W-1:0]      cur_pl,
  input  logic [PL_W-1:0]      sel_rpl,
  input  logic [PL_W-1:0]      tgt_dpl,
  input  logic                 tgt_conf,
  input  logic [PL_W-1:0]      gate_dpl,
  input  logic [PL_W-1:0]      ret_rpl,
  input  logic [NSEG*PL_W-1:0] seg_dpl,
  input  logic [NSEG-1:0]      seg_live,
  output logic                 rsp_valid,
  output logic                 rsp_ok,
  output logic [PL_W-1:0]      new_pl,
  output logic                 stk_switch,
  output logic [NSEG-1:0]      null_mask
);
  localparam logic [1:0] K_JMP  = 2'd0;
  localparam logic [1:0] K_CALL = 2'd1;
  localparam logic [1:0] K_RET  = 2'd2;

  wire [PL_W-1:0] epl = (sel_rpl > cur_pl) ? sel_rpl : cur_pl;
  wire gate_ok = epl <= gate_dpl;
  wire at_or_above = cur_pl >= tgt_dpl;
  wire same_pl = cur_pl == tgt_dpl;

  logic ok_c;
  logic [PL_W-1:0] np_c;
  logic [NSEG-1:0] drop;
  logic [NSEG-1:0] nm_c;

  always_comb begin
    ok_c = 1'b0;
    np_c = cur_pl;
    case (kind)
      K_JMP, K_CALL: begin
        if (!via_gate)
          ok_c = tgt_conf ? at_or_above : (same_pl && sel_rpl <= cur_pl);
        else if (kind == K_JMP)
          ok_c = gate_ok && (tgt_conf ? at_or_above : same_pl);
        else begin
          ok_c = gate_ok && at_or_above;
          if (!tgt_conf) np_c = tgt_dpl;
        end
      end
      K_RET: begin
        ok_c = (ret_rpl >= cur_pl) &&
               (tgt_conf ? (tgt_dpl <= ret_rpl) : (tgt_dpl == ret_rpl));
        np_c = ret_rpl;
      end
      default: ok_c = 1'b0;
    endcase
    if (!ok_c) np_c = cur_pl;
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    assign drop[i] = seg_live[i] && (seg_dpl[i*PL_W +: PL_W] < ret_rpl);
  end

  assign nm_c = (kind == K_RET && ok_c && ret_rpl > cur_pl) ? drop : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      new_pl     <= '0;
      stk_switch <= 1'b0;
      null_mask  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_ok     <= ok_c;
        new_pl     <= np_c;
        stk_switch <= np_c != cur_pl;
        null_mask  <= nm_c;
      end
    end
  end

  // R10
  strobe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  // R9
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !ok_c |=> !rsp_ok && !stk_switch && null_mask == '0 && new_pl == $past(cur_pl));

  // R4
  switch_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> stk_switch == (new_pl != $past(cur_pl)));

  // R8
  null_only_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && kind != K_RET |=> null_mask == '0);

  // R5
  conf_keeps_pl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && tgt_conf && kind != K_RET |=> new_pl == $past(cur_pl) && !stk_switch);
endmodule

// File: tb/tb_far_xfer_priv_chk.sv
`timescale 1ns/1ps
module tb_far_xfer_priv_chk;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] kind = '0;
  logic via_gate = 1'b0;
  logic [1:0] cur_pl = '0, sel_rpl = '0, tgt_dpl = '0, gate_dpl = '0, ret_rpl = '0;
  logic tgt_conf = 1'b0;
  logic [7:0] seg_dpl = '0;
  logic [3:0] seg_live = '0;
  logic rsp_valid, rsp_ok, stk_switch;
  logic [1:0] new_pl;
  logic [3:0] null_mask;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  far_xfer_priv_chk dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .kind(kind), .via_gate(via_gate),
    .cur_pl(cur_pl), .sel_rpl(sel_rpl), .tgt_dpl(tgt_dpl), .tgt_conf(tgt_conf),
    .gate_dpl(gate_dpl), .ret_rpl(ret_rpl), .seg_dpl(seg_dpl), .seg_live(seg_live),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .new_pl(new_pl), .stk_switch(stk_switch),
    .null_mask(null_mask));

  // kind, gate, cpl, rpl, dpl, conf, gdpl, rrpl | ok, new, sw
  localparam int NV = 18;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0,1'b0,2'd2,2'd1,2'd2,1'b0,2'd0,2'd0, 1'b1,2'd2,1'b0}, // R1 pass
    {2'd0,1'b0,2'd2,2'd3,2'd2,1'b0,2'd0,2'd0, 1'b0,2'd2,1'b0}, // R1 rpl above cpl
    {2'd0,1'b0,2'd3,2'd3,2'd2,1'b0,2'd0,2'd0, 1'b0,2'd3,1'b0}, // R1 cpl ne dpl
    {2'd0,1'b0,2'd3,2'd0,2'd1,1'b1,2'd0,2'd0, 1'b1,2'd3,1'b0}, // R2 keeps cpl
    {2'd1,1'b0,2'd1,2'd3,2'd2,1'b1,2'd0,2'd0, 1'b0,2'd1,1'b0}, // R2 cpl below dpl
    {2'd1,1'b1,2'd3,2'd3,2'd0,1'b0,2'd3,2'd0, 1'b1,2'd0,1'b1}, // R4 raise
    {2'd1,1'b1,2'd3,2'd3,2'd0,1'b0,2'd2,2'd0, 1'b0,2'd3,1'b0}, // R3 cpl over gate
    {2'd1,1'b1,2'd1,2'd3,2'd0,1'b0,2'd2,2'd0, 1'b0,2'd1,1'b0}, // R3 rpl over gate
    {2'd1,1'b1,2'd3,2'd0,2'd0,1'b1,2'd3,2'd0, 1'b1,2'd3,1'b0}, // R5
    {2'd0,1'b1,2'd3,2'd0,2'd0,1'b0,2'd3,2'd0, 1'b0,2'd3,1'b0}, // R6 jmp cannot raise
    {2'd0,1'b1,2'd2,2'd0,2'd2,1'b0,2'd3,2'd0, 1'b1,2'd2,1'b0}, // R6 equal
    {2'd0,1'b1,2'd3,2'd0,2'd1,1'b1,2'd3,2'd0, 1'b1,2'd3,1'b0}, // R6 conforming
    {2'd1,1'b1,2'd2,2'd0,2'd2,1'b0,2'd2,2'd0, 1'b1,2'd2,1'b0}, // R4 same level
    {2'd2,1'b0,2'd0,2'd0,2'd3,1'b0,2'd0,2'd3, 1'b1,2'd3,1'b1}, // R7 lower
    {2'd2,1'b1,2'd2,2'd0,2'd1,1'b0,2'd0,2'd1, 1'b0,2'd2,1'b0}, // R7 to more privileged
    {2'd2,1'b0,2'd1,2'd0,2'd0,1'b1,2'd0,2'd2, 1'b1,2'd2,1'b1}, // R7 conforming
    {2'd3,1'b0,2'd1,2'd1,2'd1,1'b0,2'd3,2'd1, 1'b0,2'd1,1'b0}, // R9 reserved
    {2'd1,1'b0,2'd1,2'd0,2'd1,1'b0,2'd0,2'd0, 1'b1,2'd1,1'b0}  // R1 call
  };

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [13:0] f);
    @(negedge clk);
    {kind, via_gate, cur_pl, sel_rpl, tgt_dpl, tgt_conf, gate_dpl, ret_rpl} = f;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({rsp_valid, rsp_ok, new_pl, stk_switch, null_mask} == '0, "R10 reset",
          {rsp_valid, rsp_ok, new_pl, stk_switch, null_mask}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 idle", rsp_valid, 0);
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][17:4]);
      check({rsp_valid, rsp_ok, new_pl, stk_switch} == {1'b1, VEC[i][3:0]},
            $sformatf("R1-vector %0d", i), {rsp_valid, rsp_ok, new_pl, stk_switch},
            {1'b1, VEC[i][3:0]});
      check(null_mask == 4'b0, "R8 mask zero", null_mask, 0);
    end
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 pulse", rsp_valid, 0);
    check(rsp_ok == 1'b1 && new_pl == 2'd1, "R10 hold", {rsp_ok, new_pl}, 5);
    // R8: return 0 -> 3, segs dpl {3,2,3,0} (idx3..0), all live
    seg_dpl = {2'd3, 2'd2, 2'd3, 2'd0}; seg_live = 4'b1111;
    issue({2'd2,1'b0,2'd0,2'd0,2'd3,1'b0,2'd0,2'd3});
    check(null_mask == 4'b0101, "R8 lower", null_mask, 4'b0101);
    seg_live = 4'b1110;
    issue({2'd2,1'b0,2'd0,2'd0,2'd3,1'b0,2'd0,2'd3});
    check(null_mask == 4'b0100, "R8 not live", null_mask, 4'b0100);
    seg_live = 4'b1111;
    issue({2'd2,1'b0,2'd1,2'd0,2'd2,1'b0,2'd0,2'd2});
    check(null_mask == 4'b0001, "R8 to level 2", null_mask, 4'b0001);
    issue({2'd2,1'b0,2'd3,2'd0,2'd3,1'b0,2'd0,2'd3});
    check(null_mask == 4'b0 && stk_switch == 1'b0 && rsp_ok, "R8 same level", null_mask, 0);
    issue({2'd2,1'b0,2'd0,2'd0,2'd2,1'b0,2'd0,2'd3});
    check(null_mask == 4'b0 && !rsp_ok && new_pl == 2'd0, "R9 ret fault", {rsp_ok, new_pl, null_mask}, 0);
    // R2: rpl ignored for conforming target
    issue({2'd0,1'b0,2'd2,2'd3,2'd1,1'b1,2'd0,2'd0});
    check(rsp_ok && new_pl == 2'd2, "R2 rpl ignored", {rsp_ok, new_pl}, 6);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule